// File: doc/BRIEF.md
# Hoisted-Load Guard Table

This block tracks loads that a scheduler has moved above older stores whose addresses were not known when the code was arranged. When such a load issues, it files its memory address under the number of the register it wrote. Every store that executes later broadcasts its address into the table. Any filed load that read the same location has fetched a stale value, so its entry is marked dead.

Further down the instruction stream, a verify operation names the register. The table then answers with one of two verdicts: the early value may be kept, or a recovery path has to run. The verdict arrives one cycle after the verify request. The entry for that register is released in the same step.

The table does not access memory. It does not hold or repair any data, and it does not steer the pipeline. It only detects read-after-write conflicts through memory and reports them.

Top module: `hoisted_load_guard`

## Requirements
- R1: An allocate request stores its address and register tag in a live entry. A later verify of that tag, with no matching store in between, answers pass (`chk_ok`=1, `chk_recover`=0).
- R2: A store whose address equals the address of a live entry kills that entry. A later verify of its tag answers recover (`chk_ok`=0, `chk_recover`=1).
- R3: A store whose address differs from every live entry changes nothing, so verifies of the filed tags still pass.
- R4: One store is compared against all live entries at once. Every entry with that address is killed by the same store.
- R5: A verify whose tag matches no live entry answers recover.
- R6: The verdict is registered. `chk_done` is 1 exactly in the cycle after a cycle with `check_valid`=1. When `chk_done`=1, exactly one of `chk_ok` and `chk_recover` is 1. When `chk_done`=0, both are 0.
- R7: A verify releases the entry of its tag, whatever the verdict. A second verify of the same tag answers recover unless the tag was allocated again. If an allocate of that tag arrives in the same cycle as the verify, the new entry is live afterwards.
- R8: An allocate whose tag is already held by a live entry overwrites that entry, so no two live entries share a tag. A store to the replaced address no longer affects the tag.
- R9: Without a tag match, an allocate takes the lowest-index free entry. When all entries are live, it evicts the entry at a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each eviction. A verify of an evicted tag answers recover.
- R10: When an allocate and a store with the same address arrive in the same cycle, the store is ordered first and the new entry stays live.
- R11: When a store and a verify arrive in the same cycle, the store is ordered first. A verify whose live entry the store kills answers recover.
- R12: A synchronous active-high `rst` kills every entry and clears all verdict outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | File a hoisted load |
| alloc_addr | input | ADDR_W | Address read by the hoisted load |
| alloc_reg | input | REG_W | Destination register tag of the hoisted load |
| store_valid | input | 1 | A store is executing |
| store_addr | input | ADDR_W | Address written by the store |
| check_valid | input | 1 | Verify request |
| check_reg | input | REG_W | Register tag to verify |
| chk_done | output | 1 | Verdict valid, one cycle after the request |
| chk_ok | output | 1 | Early value may be kept |
| chk_recover | output | 1 | Recovery needed |

## Verification
A store can coincide with an allocate or a verify, and these collisions carry the ordering rules.

The bench drives a store and an allocate of the same address in one cycle, and expects the new entry to survive a later verify. It also drives a store and a verify of a live tag at that address in one cycle, and expects a recover verdict in the next cycle. A verify and a re-allocate of one tag are also driven together, and the tag must still pass afterwards.

A behavioural model applies the same ordering to every cycle of the run, and its verdicts are compared with the outputs on every clock.

// File: rtl/hlg_pkg.sv
package hlg_pkg;
   // Source chosen for the entry written by an allocate request
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_REUSE = 2'd1,
      WR_FREE  = 2'd2,
      WR_EVICT = 2'd3
   } wr_src_e;
endpackage

// File: rtl/hlg_pick.sv
// Lowest-index selector over a request vector.
module hlg_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 1) begin : g_bad_n
      $error("hlg_pick: N must be at least 1");
   end

   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/hlg_slot.sv
// One table entry: live bit, address and register tag, plus its comparators.
module hlg_slot #(
   parameter int AW = 32,
   parameter int RW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          st_en,
   input  logic [AW-1:0] st_addr,
   input  logic          ck_en,
   input  logic [RW-1:0] ck_tag,
   input  logic [RW-1:0] al_tag,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [RW-1:0] wr_tag,
   output logic          live_q,
   output logic [RW-1:0] tag_q,
   output logic          snoop_hit,
   output logic          ck_hit,
   output logic          al_hit,
   output logic          keep_mid
);
   logic [AW-1:0] addr_q;

   assign snoop_hit = live_q & st_en & (addr_q == st_addr);
   assign ck_hit    = live_q & ck_en & (tag_q == ck_tag);
   assign al_hit    = live_q & (tag_q == al_tag);
   // survives the store snoop and the verify release of this cycle
   assign keep_mid  = live_q & ~snoop_hit & ~ck_hit;

   always_ff @(posedge clk) begin
      if (rst) live_q <= 1'b0;
      else     live_q <= wr_en | keep_mid;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         addr_q <= wr_addr;
         tag_q  <= wr_tag;
      end
   end
endmodule

// File: rtl/hoisted_load_guard.sv
module hoisted_load_guard #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int REG_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              alloc_valid,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [REG_W-1:0]  alloc_reg,
   input  logic              store_valid,
   input  logic [ADDR_W-1:0] store_addr,
   input  logic              check_valid,
   input  logic [REG_W-1:0]  check_reg,
   output logic              chk_done,
   output logic              chk_ok,
   output logic              chk_recover
);
   import hlg_pkg::*;

   localparam int  IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  POW2   = (DEPTH == (1 << IW));
   localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("hoisted_load_guard: DEPTH must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("hoisted_load_guard: ADDR_W must be positive");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("hoisted_load_guard: REG_W must be positive");
   end

   logic [DEPTH-1:0]            live_vec;
   logic [DEPTH-1:0][REG_W-1:0] tag_vec;
   logic [DEPTH-1:0]            snoop_vec;
   logic [DEPTH-1:0]            ck_vec;
   logic [DEPTH-1:0]            al_vec;
   logic [DEPTH-1:0]            keep_vec;
   logic [DEPTH-1:0]            wr_vec;

   logic          reuse_found, free_found;
   logic [IW-1:0] reuse_idx, free_idx, wr_idx, rr_q, rr_next;
   wr_src_e       wr_src;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      hlg_slot #(.AW(ADDR_W), .RW(REG_W)) u_slot (
         .clk       (clk),
         .rst       (rst),
         .st_en     (store_valid),
         .st_addr   (store_addr),
         .ck_en     (check_valid),
         .ck_tag    (check_reg),
         .al_tag    (alloc_reg),
         .wr_en     (wr_vec[g]),
         .wr_addr   (alloc_addr),
         .wr_tag    (alloc_reg),
         .live_q    (live_vec[g]),
         .tag_q     (tag_vec[g]),
         .snoop_hit (snoop_vec[g]),
         .ck_hit    (ck_vec[g]),
         .al_hit    (al_vec[g]),
         .keep_mid  (keep_vec[g])
      );
      assign wr_vec[g] = (wr_src != WR_NONE) && (wr_idx == IW'(g));
   end

   // tag reuse: at most one live entry carries a given tag
   hlg_pick #(.N(DEPTH)) u_reuse (
      .req   (al_vec),
      .found (reuse_found),
      .idx   (reuse_idx)
   );

   // free entries after this cycle's store snoop and verify release
   hlg_pick #(.N(DEPTH)) u_free (
      .req   (~keep_vec),
      .found (free_found),
      .idx   (free_idx)
   );

   always_comb begin
      if (!alloc_valid)      wr_src = WR_NONE;
      else if (reuse_found)  wr_src = WR_REUSE;
      else if (free_found)   wr_src = WR_FREE;
      else                   wr_src = WR_EVICT;
   end

   always_comb begin
      unique case (wr_src)
         WR_REUSE: wr_idx = reuse_idx;
         WR_FREE:  wr_idx = free_idx;
         default:  wr_idx = rr_q;
      endcase
   end

   // rotating victim pointer: natural wrap for power-of-two depth
   if (POW2) begin : g_rr_pow2
      assign rr_next = rr_q + 1'b1;
   end else begin : g_rr_wrap
      assign rr_next = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                    rr_q <= '0;
      else if (wr_src == WR_EVICT) rr_q <= rr_next;
   end

   // registered verdict; the store of the same cycle is ordered first
   logic pass_now;
   assign pass_now = |(ck_vec & ~snoop_vec);

   always_ff @(posedge clk) begin
      if (rst) begin
         chk_done    <= 1'b0;
         chk_ok      <= 1'b0;
         chk_recover <= 1'b0;
      end else begin
         chk_done    <= check_valid;
         chk_ok      <= check_valid & pass_now;
         chk_recover <= check_valid & ~pass_now;
      end
   end
endmodule

// File: rtl/hlg_checker.sv
module hlg_checker #(
   parameter int DEPTH = 8,
   parameter int REG_W = 6
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        alloc_valid,
   input logic                        check_valid,
   input logic                        chk_done,
   input logic                        chk_ok,
   input logic                        chk_recover,
   input logic [DEPTH-1:0]            slot_valid,
   input logic [DEPTH-1:0][REG_W-1:0] slot_tag
);
   logic dup_tag;

   always_comb begin
      dup_tag = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         for (int j = i + 1; j < DEPTH; j++) begin
            if (slot_valid[i] && slot_valid[j] && slot_tag[i] == slot_tag[j])
               dup_tag = 1'b1;
         end
      end
   end

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
      chk_done |-> (chk_ok != chk_recover)); // R6
   AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (rst)
      !chk_done |-> (!chk_ok && !chk_recover)); // R6
   AST_VERDICT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      check_valid |=> chk_done); // R6
   AST_NO_UNASKED_VERDICT: assert property (@(posedge clk) disable iff (rst)
      !check_valid |=> !chk_done); // R6
   AST_ALLOC_LIVE: assert property (@(posedge clk) disable iff (rst)
      alloc_valid |=> (slot_valid != '0)); // R1
   AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
      !dup_tag); // R8
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (slot_valid == '0 && !chk_done)); // R12
endmodule

bind hoisted_load_guard hlg_checker #(.DEPTH(DEPTH), .REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .alloc_valid (alloc_valid),
   .check_valid (check_valid),
   .chk_done    (chk_done),
   .chk_ok      (chk_ok),
   .chk_recover (chk_recover),
   .slot_valid  (live_vec),
   .slot_tag    (tag_vec)
);

// File: tb/hoisted_load_guard_test.sv
`timescale 1ns/1ps
module hoisted_load_guard_test;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        alloc_valid = 1'b0;
   logic [31:0] alloc_addr = '0;
   logic [5:0]  alloc_reg = '0;
   logic        store_valid = 1'b0;
   logic [31:0] store_addr = '0;
   logic        check_valid = 1'b0;
   logic [5:0]  check_reg = '0;
   logic        chk_done, chk_ok, chk_recover;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   string cur_req = "R12";

   // behavioural reference state
   bit          m_v [N];
   logic [31:0] m_a [N];
   logic [5:0]  m_t [N];
   int          m_rr;

   always #10 clk = ~clk;

   hoisted_load_guard uut (
      .clk(clk), .rst(rst),
      .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_reg(alloc_reg),
      .store_valid(store_valid), .store_addr(store_addr),
      .check_valid(check_valid), .check_reg(check_reg),
      .chk_done(chk_done), .chk_ok(chk_ok), .chk_recover(chk_recover)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
         summary();
         $finish;
      end
   end

   task automatic cmp(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: done/ok/recover actual=%b expected=%b", req, act, exp);
      end
   endtask

   // one clock with the model stepped alongside; compare at the next falling edge
   task automatic step(input logic av, input logic [31:0] aa, input logic [5:0] ar,
                       input logic sv, input logic [31:0] sa,
                       input logic cv, input logic [5:0] cr);
      bit nv [N];
      bit e_ok;
      int idx;
      alloc_valid = av; alloc_addr = aa; alloc_reg = ar;
      store_valid = sv; store_addr = sa;
      check_valid = cv; check_reg = cr;
      e_ok = 0;
      for (int i = 0; i < N; i++) begin
         bool_hit: begin end
         if (cv && m_v[i] && m_t[i] == cr && !(sv && m_a[i] == sa)) e_ok = 1;
         nv[i] = m_v[i] && !(sv && m_a[i] == sa) && !(cv && m_t[i] == cr);
      end
      if (av) begin
         idx = -1;
         for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == ar) idx = i;
         if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!nv[i]) idx = i;
         if (idx < 0) begin
            idx = m_rr;
            m_rr = (m_rr + 1) % N;
         end
         nv[idx] = 1; m_a[idx] = aa; m_t[idx] = ar;
      end
      for (int i = 0; i < N; i++) m_v[i] = nv[i];
      @(posedge clk);
      @(negedge clk);
      cmp(cur_req, {chk_done, chk_ok, chk_recover}, {cv, cv && e_ok, cv && !e_ok});
      alloc_valid = 0; store_valid = 0; check_valid = 0;
   endtask

   task automatic idle();
      step(0, '0, '0, 0, '0, 0, '0);
   endtask
   task automatic alloc(input logic [5:0] r, input logic [31:0] a);
      step(1, a, r, 0, '0, 0, '0);
   endtask
   task automatic store(input logic [31:0] a);
      step(0, '0, '0, 1, a, 0, '0);
   endtask
   // verify with a hand-derived expectation
   task automatic verify(input logic [5:0] r, input bit exp_ok, input string req);
      step(0, '0, '0, 0, '0, 1, r);
      cmp(req, {chk_done, chk_ok, chk_recover}, {1'b1, exp_ok, !exp_ok});
   endtask

   task automatic do_reset(input string req);
      rst = 1;
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0;
      cmp(req, {chk_done, chk_ok, chk_recover}, 3'b000);
      rst = 0;
   endtask

   initial begin
      @(negedge clk);
      do_reset("R12");
      do_reset("R12");

      cur_req = "R1";  alloc(6'd1, 32'h1000); idle(); verify(6'd1, 1, "R1");
      cur_req = "R6";  idle(); cmp("R6", {chk_done, chk_ok, chk_recover}, 3'b000);
      cur_req = "R2";  alloc(6'd2, 32'h2000); store(32'h2000); verify(6'd2, 0, "R2");
      cur_req = "R3";  alloc(6'd3, 32'h3000); store(32'h3004); verify(6'd3, 1, "R3");
      cur_req = "R4";  alloc(6'd4, 32'h4000); alloc(6'd5, 32'h4000); store(32'h4000);
      verify(6'd4, 0, "R4"); verify(6'd5, 0, "R4");
      cur_req = "R5";  verify(6'd9, 0, "R5");
      cur_req = "R7";  alloc(6'd6, 32'h6000); verify(6'd6, 1, "R7"); verify(6'd6, 0, "R7");
      alloc(6'd8, 32'h8000);
      step(1, 32'h8100, 6'd8, 0, '0, 1, 6'd8);
      cmp("R7", {chk_done, chk_ok, chk_recover}, 3'b110);
      verify(6'd8, 1, "R7");
      cur_req = "R8";  alloc(6'd7, 32'h7000); alloc(6'd7, 32'h7100); store(32'h7000);
      verify(6'd7, 1, "R8");

      cur_req = "R9";
      for (int k = 0; k < N; k++) alloc(6'(10 + k), 32'h9000 + 32'(k * 16));
      alloc(6'd18, 32'h9800);            // table full: evicts slot 0 (tag 10)
      verify(6'd10, 0, "R9"); verify(6'd18, 1, "R9");
      alloc(6'd19, 32'h9900);            // slot 0 free again
      alloc(6'd20, 32'h9a00);            // full: evicts slot 1 (tag 11)
      verify(6'd11, 0, "R9"); verify(6'd12, 1, "R9"); verify(6'd19, 1, "R9");

      cur_req = "R12"; alloc(6'd30, 32'hA000); do_reset("R12");
      verify(6'd30, 0, "R12"); verify(6'd13, 0, "R12");

      cur_req = "R10";
      step(1, 32'hB000, 6'd21, 1, 32'hB000, 0, '0);
      verify(6'd21, 1, "R10");
      cur_req = "R11"; alloc(6'd22, 32'hC000);
      step(0, '0, '0, 1, 32'hC000, 1, 6'd22);
      cmp("R11", {chk_done, chk_ok, chk_recover}, 3'b101);
      alloc(6'd23, 32'hC100);
      step(0, '0, '0, 1, 32'hC200, 1, 6'd23);
      cmp("R11", {chk_done, chk_ok, chk_recover}, 3'b110);
      idle(); idle();
      summary();
      $finish;
   end
endmodule